// File: doc/BRIEF.md
# Receive Frame Pulse Offset Aligner

The aligner places the start of each receive frame at a programmable distance from a system frame pulse. It runs on an internal clock at twice the line bit rate, so each internal cycle stands for one edge of the line clock, rising or falling. When a rising edge of the frame-pulse input is seen, the block waits a computed number of line-clock edges and then raises a one-cycle frame-start marker.

The wait has two parts. The bit part is a clock-edge count. Its base value depends on whether the frame pulse and the data are taken on the same line-clock edge. The 3-bit bit offset and the frame-pulse mode each add to it. The bit part only counts when bit offset is enabled and double-clock mode is off. The timeslot part comes after it: a 7-bit timeslot count with eight bits, or sixteen edges, per timeslot.

A position counter runs beside the marker for the data shifter. It gives the edge phase within a bit, the bit within a timeslot and the timeslot within the frame. The counter is zero in the same cycle the marker is high, so both stay aligned to the serial data.

Top module: `fpa_frame_aligner`

## Requirements
- R1: During and right after synchronous reset, `frame_start`, `edge_phase`, `bit_idx` and `slot_idx` are all 0.
- R2: With bit offset enabled, double-clock off, `fp_mode`=0, `ts_off`=0 and `boff`=000, the delay is 2 edges when `fp_edge_sel` equals `data_edge_sel`, and 1 edge when they differ.
- R3: Each step of `boff` adds 2 edges to the delay. At 111 with `fp_mode`=0 the delay is 16 edges for equal edge selects and 15 for different ones.
- R4: `fp_mode`=1 adds 2 edges to the bit part. This gives 4/3 edges at `boff`=000 and 18/17 at 111.
- R5: With `boff_en`=0, the bit part is 0 edges whatever `boff`, the edge selects and `fp_mode` hold.
- R6: With `dbl_clk`=1, the bit part is 0 edges even when `boff_en`=1.
- R7: Each unit of `ts_off` adds 16 edges (8 bits of 2 edges each), on top of the bit part.
- R8: The delay D is counted from the cycle in which `fp_in` is first sampled high after being low. `frame_start` is high for exactly one cycle, in the cycle after the D-th edge that follows that cycle. With D=0 it is high in the cycle after the detecting edge.
- R9: `edge_phase`, `bit_idx` and `slot_idx` are 0 while `frame_start` is high. After that, the phase toggles every cycle, `bit_idx` steps when the phase goes from 1 to 0, and `slot_idx` steps when `bit_idx` wraps from 7. `slot_idx` wraps to 0 after SLOTS-1.
- R10: A new rising edge of `fp_in` while a delay is still pending restarts the count from that edge. The earlier pulse then produces no marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, two cycles per line bit |
| rst | input | 1 | Synchronous active-high reset |
| fp_in | input | 1 | System frame pulse, active on its rising edge |
| ts_off | input | 7 | Timeslot offset |
| boff_en | input | 1 | Bit offset enable |
| boff | input | 3 | Bit offset |
| fp_edge_sel | input | 1 | Line-clock edge on which the frame pulse is taken |
| data_edge_sel | input | 1 | Line-clock edge on which data is driven |
| fp_mode | input | 1 | Frame-pulse mode, 1 adds two edges |
| dbl_clk | input | 1 | Double-clock mode, disables bit offset |
| frame_start | output | 1 | One-cycle frame-start marker |
| edge_phase | output | 1 | Edge within the current bit |
| bit_idx | output | 3 | Bit within the current timeslot |
| slot_idx | output | 5 | Timeslot within the frame |

## Verification
On every cycle, the checker confirms four things. The offset arithmetic drops the bit part whenever it is disabled or double-clock mode is on. The marker never lasts two cycles. The position counter reads zero under the marker. The phase toggles on every cycle that has no marker. The exact edge counts need whole scenarios from the bench: the base count for each edge-select pairing, the step per bit offset, the frame-pulse mode addition, the timeslot weight, the restart on an early second pulse and the slot wrap. The bench measures the distance from the pulse to the marker against its own computed delay.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int unsigned EDGES_PER_BIT = 2;
  localparam int unsigned BITS_PER_SLOT = 8;
  localparam int unsigned EDGES_PER_SLOT = EDGES_PER_BIT * BITS_PER_SLOT;
  localparam int unsigned MODE_EXTRA = 2;
endpackage

// File: rtl/fpa_offset_calc.sv
module fpa_offset_calc #(
  parameter int TS_W   = 7,
  parameter int BOFF_W = 3,
  parameter int DLY_W  = TS_W + 5
) (
  input  logic [TS_W-1:0]   ts_off,
  input  logic              boff_en,
  input  logic [BOFF_W-1:0] boff,
  input  logic              fp_edge_sel,
  input  logic              data_edge_sel,
  input  logic              fp_mode,
  input  logic              dbl_clk,
  output logic [DLY_W-1:0]  dly
);
  import fpa_pkg::*;

  logic [DLY_W-1:0] bit_part;
  logic [DLY_W-1:0] slot_part;
  logic [DLY_W-1:0] base_edges;

  always_comb begin
    base_edges = (fp_edge_sel == data_edge_sel) ? DLY_W'(2) : DLY_W'(1);
    bit_part   = '0;
    if (boff_en && !dbl_clk) begin
      bit_part = base_edges + DLY_W'(boff) * DLY_W'(EDGES_PER_BIT);
      if (fp_mode) bit_part = bit_part + DLY_W'(MODE_EXTRA);
    end
    slot_part = DLY_W'(ts_off) * DLY_W'(EDGES_PER_SLOT);
    dly       = slot_part + bit_part;
  end
endmodule

// File: rtl/fpa_start_timer.sv
module fpa_start_timer #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_in,
  input  logic [DLY_W-1:0] dly,
  output logic             start_next,
  output logic             frame_start
);
  logic             fp_q;
  logic             busy;
  logic [DLY_W-1:0] cnt;
  logic             fp_rise;

  assign fp_rise    = fp_in && !fp_q;
  assign start_next = fp_rise ? (dly == '0) : (busy && cnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_q        <= 1'b0;
      busy        <= 1'b0;
      cnt         <= '0;
      frame_start <= 1'b0;
    end else begin
      fp_q        <= fp_in;
      frame_start <= start_next;
      if (fp_rise) begin
        cnt  <= dly;
        busy <= (dly != '0);
      end else if (busy) begin
        cnt <= cnt - DLY_W'(1);
        if (cnt == DLY_W'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpa_pos_counter.sv
module fpa_pos_counter #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic              edge_phase,
  output logic [2:0]        bit_idx,
  output logic [SLOT_W-1:0] slot_idx
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      edge_phase <= 1'b0;
      bit_idx    <= '0;
      slot_idx   <= '0;
    end else begin
      edge_phase <= ~edge_phase;
      if (edge_phase) begin
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          if (slot_idx == SLOT_W'(SLOTS - 1)) slot_idx <= '0;
          else slot_idx <= slot_idx + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fpa_frame_aligner.sv
module fpa_frame_aligner #(
  parameter int TS_W   = 7,
  parameter int BOFF_W = 3,
  parameter int SLOTS  = 32,
  localparam int DLY_W  = TS_W + 5,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fp_in,
  input  logic [TS_W-1:0]   ts_off,
  input  logic              boff_en,
  input  logic [BOFF_W-1:0] boff,
  input  logic              fp_edge_sel,
  input  logic              data_edge_sel,
  input  logic              fp_mode,
  input  logic              dbl_clk,
  output logic              frame_start,
  output logic              edge_phase,
  output logic [2:0]        bit_idx,
  output logic [SLOT_W-1:0] slot_idx
);
  logic [DLY_W-1:0] dly;
  logic             start_next;

  fpa_offset_calc #(.TS_W(TS_W), .BOFF_W(BOFF_W), .DLY_W(DLY_W)) u_calc (
    .ts_off(ts_off), .boff_en(boff_en), .boff(boff),
    .fp_edge_sel(fp_edge_sel), .data_edge_sel(data_edge_sel),
    .fp_mode(fp_mode), .dbl_clk(dbl_clk), .dly(dly)
  );

  fpa_start_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .fp_in(fp_in), .dly(dly),
    .start_next(start_next), .frame_start(frame_start)
  );

  fpa_pos_counter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pos (
    .clk(clk), .rst(rst), .restart(start_next),
    .edge_phase(edge_phase), .bit_idx(bit_idx), .slot_idx(slot_idx)
  );
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter int TS_W   = 7,
  parameter int DLY_W  = 12,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [TS_W-1:0]   ts_off,
  input logic              boff_en,
  input logic              dbl_clk,
  input logic [DLY_W-1:0]  dly,
  input logic              frame_start,
  input logic              edge_phase,
  input logic [2:0]        bit_idx,
  input logic [SLOT_W-1:0] slot_idx
);
  logic [DLY_W-1:0] slot_only;
  assign slot_only = DLY_W'(ts_off) << 4;

  p_no_boff_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !boff_en |-> dly == slot_only);

  p_no_boff_dblclk_r6: assert property (@(posedge clk) disable iff (rst)
    dbl_clk |-> dly == slot_only);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  p_zero_at_start_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (!edge_phase && bit_idx == 3'd0 && slot_idx == '0));

  p_phase_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frame_start || edge_phase != $past(edge_phase)));
endmodule

bind fpa_frame_aligner fpa_checker #(.TS_W(TS_W), .DLY_W(DLY_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .ts_off(ts_off), .boff_en(boff_en), .dbl_clk(dbl_clk),
  .dly(dly), .frame_start(frame_start), .edge_phase(edge_phase),
  .bit_idx(bit_idx), .slot_idx(slot_idx)
);

// File: tb/fpa_frame_aligner_bench.sv
`timescale 1ns/1ps
module fpa_frame_aligner_bench;
  localparam int SLOTS = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp_in = 1'b0;
  logic [6:0] ts_off = '0;
  logic       boff_en = 1'b0;
  logic [2:0] boff = '0;
  logic       fp_edge_sel = 1'b0;
  logic       data_edge_sel = 1'b0;
  logic       fp_mode = 1'b0;
  logic       dbl_clk = 1'b0;
  logic       frame_start;
  logic       edge_phase;
  logic [2:0] bit_idx;
  logic [4:0] slot_idx;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  fpa_frame_aligner #(.SLOTS(SLOTS)) u_fpa_frame_aligner (
    .clk(clk), .rst(rst), .fp_in(fp_in), .ts_off(ts_off), .boff_en(boff_en),
    .boff(boff), .fp_edge_sel(fp_edge_sel), .data_edge_sel(data_edge_sel),
    .fp_mode(fp_mode), .dbl_clk(dbl_clk), .frame_start(frame_start),
    .edge_phase(edge_phase), .bit_idx(bit_idx), .slot_idx(slot_idx)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  function automatic int exp_dly(input logic [6:0] t, input logic en, input logic [2:0] b,
                                 input logic fe, input logic de, input logic m, input logic dc);
    int bits;
    bits = 0;
    if (en && !dc) bits = ((fe == de) ? 2 : 1) + 2 * int'(b) + (m ? 2 : 0);
    return bits + 16 * int'(t);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic set_cfg(input logic [6:0] t, input logic en, input logic [2:0] b,
                         input logic fe, input logic de, input logic m, input logic dc);
    ts_off = t; boff_en = en; boff = b; fp_edge_sel = fe;
    data_edge_sel = de; fp_mode = m; dbl_clk = dc;
  endtask

  // raise fp at a negedge, return number of edges until the marker is seen
  task automatic measure(output int k);
    k = -1;
    fp_in = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      fp_in = 1'b0;
      if (frame_start) begin k = i; break; end
    end
  endtask

  task automatic run_one(input string req);
    int k;
    @(negedge clk);
    measure(k);
    check(req, k, exp_dly(ts_off, boff_en, boff, fp_edge_sel, data_edge_sel, fp_mode, dbl_clk));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int k;
    int seen;
    repeat (3) @(negedge clk);
    check("R1 frame_start", int'(frame_start), 0);
    check("R1 position", int'({edge_phase, bit_idx, slot_idx}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", int'(frame_start), 0);

    // R2: base edge count
    set_cfg(0, 1, 0, 0, 0, 0, 0); run_one("R2 same edges");
    set_cfg(0, 1, 0, 1, 1, 0, 0); run_one("R2 same edges hi");
    set_cfg(0, 1, 0, 0, 1, 0, 0); run_one("R2 differing edges");
    // R3: bit offset steps
    set_cfg(0, 1, 7, 1, 1, 0, 0); run_one("R3 boff 111 same");
    set_cfg(0, 1, 7, 1, 0, 0, 0); run_one("R3 boff 111 diff");
    set_cfg(0, 1, 3, 0, 0, 0, 0); run_one("R3 boff 011");
    // R4: frame-pulse mode
    set_cfg(0, 1, 0, 0, 0, 1, 0); run_one("R4 mode1 000 same");
    set_cfg(0, 1, 7, 0, 1, 1, 0); run_one("R4 mode1 111 diff");
    // R5, R6: bit part dropped
    set_cfg(2, 0, 7, 0, 0, 1, 0); run_one("R5 boff disabled");
    set_cfg(2, 1, 7, 0, 1, 1, 1); run_one("R6 double clock");
    set_cfg(0, 0, 5, 1, 0, 1, 0); run_one("R8 zero delay");
    // R7: timeslot weight
    set_cfg(1, 1, 0, 0, 0, 0, 0); run_one("R7 one slot");
    set_cfg(127, 1, 7, 0, 0, 1, 0); run_one("R7 max slot");

    // R10: restart on early second pulse
    set_cfg(1, 1, 2, 0, 0, 0, 0);
    @(negedge clk);
    fp_in = 1'b1;
    seen = 0;
    @(negedge clk); fp_in = 1'b0; seen |= int'(frame_start);
    repeat (3) begin @(negedge clk); seen |= int'(frame_start); end
    measure(k);
    check("R10 restart delay", k, exp_dly(1, 1, 2, 0, 0, 0, 0));
    check("R10 no early marker", seen, 0);

    // R9: position counter after the marker
    for (int j = 1; j <= 520; j++) begin
      @(negedge clk);
      if (j == 1 || j == 2 || j == 37 || j == 511 || j == 512 || j == 519)
        check($sformatf("R9 position at %0d", j),
              int'({slot_idx, bit_idx, edge_phase}),
              int'({5'((j / 16) % SLOTS), 3'((j / 2) % 8), 1'(j % 2)}));
    end

    // random mix, R2..R8
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 50; r++) begin
      logic [6:0] t;
      t = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 4);
      set_cfg(t, 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom % 4 == 0));
      run_one("R8 random config");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule